// File: doc/BRIEF.md
# Timestamped Transmit Sample Scheduler

This block sits between one transmit channel's packet buffer and that channel's transmit chain. It reads packets word by word from the buffer: a timestamp, a descriptor with frame flags and a sample count, then the samples. It holds each packet until a free-running time counter reaches the packet's timestamp. From then on it hands one interleaved I/Q sample to the transmit chain on each transmit clock enable. A packet whose time has already gone by is discarded without output and reported as late.

Packets are grouped into frames. A descriptor with the frame-start flag opens a frame. The packet whose descriptor carries the frame-end flag closes it once its last sample is consumed, and a one-packet frame carries both flags. Running dry while a frame is open is an underrun. Running dry outside a frame is a legal idle. Late and underrun conditions each raise a one-cycle event and a sticky bit, and software clears the sticky bits with a write-one-to-clear input.

The buffer side is a valid/ready stream. A word moves only in a cycle where `buf_valid` and `buf_ready` are both high, and the buffer must hold `buf_data` stable while `buf_ready` is low. The sample output has no back-pressure: it is paced by `tx_tick` alone.

Top module: `tx_time_sched`

## Requirements
- R1: `time_now` is 0 while `rst_n` is low and rises by exactly one on every clock after that, including across the carry from bit 15 into bit 16.
- R2: A packet is the word sequence: timestamp; descriptor (bit 31 frame start, bit 30 frame end, bits 29:0 sample count); then count sample words with I in bits 31:16 and Q in bits 15:0, presented on `smp_i`/`smp_q` unchanged.
- R3: No sample word of a packet is consumed before `time_now` equals its timestamp. With the header already buffered and `tx_tick` high on every cycle, the first sample's `smp_valid` appears while `time_now` equals timestamp + 2.
- R4: While a packet is being released, a sample word is consumed only in a cycle with `tx_tick`, `buf_valid` and `buf_ready` all high. `smp_valid` pulses in the next cycle with that word, and exactly count samples come out per packet.
- R5: A packet found waiting with a timestamp earlier than `time_now` (signed 32-bit difference) raises `late_evt` for one cycle, and its sample words are drained at one per cycle with no `smp_valid`.
- R6: A `tx_tick` that finds the buffer empty while a frame is open, and the engine is not holding for a timestamp, raises `undr_evt` one cycle later.
- R7: After the frame-end packet's last sample, an empty buffer with ticks running raises no underrun, and neither does a gap inside a frame that is spent holding for the next packet's timestamp.
- R8: `late_sticky` and `undr_sticky` set on their events and hold until `sts_clr` bit 0 (late) or bit 1 (underrun) is high on a clock edge. A new event in the same cycle wins over the clear.
- R9: After reset, `buf_ready` is 1 and `smp_valid`, both event outputs and both sticky bits are 0.
- R10: `buf_ready` is high while reading a header or draining a late packet. While releasing it is high only when `tx_tick` is high, and it is low while holding for the timestamp.
- R11: A descriptor with count 0 produces no samples, and the next word is taken as the following packet's timestamp without any time comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| buf_data | input | 32 | Word from the channel buffer |
| buf_valid | input | 1 | Buffer word is present |
| buf_ready | output | 1 | Engine takes the word this cycle if valid |
| tx_tick | input | 1 | Transmit clock enable |
| sts_clr | input | 2 | Write-one-to-clear: bit 0 late, bit 1 underrun |
| smp_valid | output | 1 | Sample strobe, one cycle per sample |
| smp_i | output | 16 | In-phase sample |
| smp_q | output | 16 | Quadrature sample |
| late_evt | output | 1 | One-cycle late-packet event |
| undr_evt | output | 1 | One-cycle underrun event |
| late_sticky | output | 1 | Sticky late flag |
| undr_sticky | output | 1 | Sticky underrun flag |
| time_now | output | 32 | Current value of the time counter |

## Verification
Release is tried with headers queued well ahead, so that the exact-match cycle is visible. It is also tried with a timestamp already in the past, which separates holding from draining, and with a timestamp just beyond the 16-bit carry, which exposes any skew between the counter halves. Frames are exercised three ways: a start packet whose data runs out, so the underrun has to fire; a two-packet frame with a timestamp gap between the packets plus an idle stretch after the end flag, where no underrun may fire; and a slower tick. A zero-count packet and a buffer that is valid only every other cycle check that words move only under the handshake. A behavioural model in the bench predicts every output on every clock.

// File: rtl/tx_sched_pkg.sv
package tx_sched_pkg;

  typedef enum logic [2:0] {
    ST_HDR_TS,
    ST_HDR_LEN,
    ST_HOLD,
    ST_SEND,
    ST_DRAIN
  } rel_state_e;

endpackage

// File: rtl/sched_time_ctr.sv
// Free-running time base split into two halves; the carry into the upper
// half is registered, so the upper half lags by one cycle after a wrap.
module sched_time_ctr #(
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [HALF_W-1:0] lo_q,
  output logic [HALF_W-1:0] hi_q,
  output logic              cy_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
      cy_q <= 1'b0;
    end else begin
      lo_q <= lo_q + 1'b1;
      cy_q <= &lo_q;
      hi_q <= hi_q + HALF_W'(cy_q);
    end
  end

endmodule

// File: rtl/sched_time_cmp.sv
// Rebuilds the true time from the skewed halves and compares a timestamp.
module sched_time_cmp #(
  parameter int TIME_W = 32
) (
  input  logic [TIME_W-1:0]   ts,
  input  logic [TIME_W/2-1:0] lo,
  input  logic [TIME_W/2-1:0] hi,
  input  logic                cy,
  output logic [TIME_W-1:0]   now,
  output logic                at_time,
  output logic                past
);

  localparam int HALF_W = TIME_W / 2;

  logic [HALF_W-1:0] hi_eff;
  logic [TIME_W-1:0] diff;

  always_comb begin
    hi_eff  = hi + HALF_W'(cy);
    now     = {hi_eff, lo};
    at_time = (ts[HALF_W-1:0] == lo) && (ts[TIME_W-1:HALF_W] == hi_eff);
    diff    = ts - now;
    past    = diff[TIME_W-1];
  end

endmodule

// File: rtl/sched_flags.sv
// One registered event and one sticky bit per status source.
module sched_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] hit,
  input  logic [N-1:0] clr,
  output logic [N-1:0] evt,
  output logic [N-1:0] sticky
);

  for (genvar g = 0; g < N; g++) begin : g_flag
    logic ev_q;
    logic st_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ev_q <= 1'b0;
        st_q <= 1'b0;
      end else begin
        ev_q <= hit[g];
        st_q <= hit[g] | (st_q & ~clr[g]);
      end
    end
    assign evt[g]    = ev_q;
    assign sticky[g] = st_q;
  end

endmodule

// File: rtl/sched_release_fsm.sv
// Header parsing, hold-until-time, paced release, late drain, frame tracking.
module sched_release_fsm
  import tx_sched_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] buf_data,
  input  logic              buf_valid,
  output logic              buf_ready,
  input  logic              tx_tick,
  input  logic              at_time,
  input  logic              past,
  output logic [WORD_W-1:0] ts_q,
  output logic              smp_valid,
  output logic [WORD_W/2-1:0] smp_i,
  output logic [WORD_W/2-1:0] smp_q,
  output logic              late_hit,
  output logic              undr_hit
);

  localparam int SMP_W = WORD_W / 2;
  localparam int CNT_W = WORD_W - 2;
  localparam int S_POS = WORD_W - 1;
  localparam int E_POS = WORD_W - 2;

  rel_state_e       st_q;
  logic [CNT_W-1:0] left_q;
  logic             e_q;
  logic             frame_q;

  logic             take;
  logic             last;
  logic             pkt_done;
  logic             pkt_e;
  logic [CNT_W-1:0] len_in;

  always_comb begin
    buf_ready = (st_q == ST_HDR_TS) || (st_q == ST_HDR_LEN) ||
                (st_q == ST_DRAIN)  || ((st_q == ST_SEND) && tx_tick);
    take      = buf_ready && buf_valid;
    len_in    = buf_data[CNT_W-1:0];
    last      = (left_q == CNT_W'(1));
    late_hit  = (st_q == ST_HOLD) && !at_time && past;
    undr_hit  = tx_tick && frame_q && !buf_valid &&
                ((st_q == ST_HDR_TS) || (st_q == ST_HDR_LEN) || (st_q == ST_SEND));
    pkt_done  = ((st_q == ST_HDR_LEN) && take && (len_in == '0)) ||
                (((st_q == ST_SEND) || (st_q == ST_DRAIN)) && take && last);
    pkt_e     = (st_q == ST_HDR_LEN) ? buf_data[E_POS] : e_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_HDR_TS;
      ts_q      <= '0;
      left_q    <= '0;
      e_q       <= 1'b0;
      frame_q   <= 1'b0;
      smp_valid <= 1'b0;
      smp_i     <= '0;
      smp_q     <= '0;
    end else begin
      smp_valid <= (st_q == ST_SEND) && take;
      if ((st_q == ST_SEND) && take) begin
        smp_i <= buf_data[WORD_W-1:SMP_W];
        smp_q <= buf_data[SMP_W-1:0];
      end

      if (pkt_done && pkt_e) begin
        frame_q <= 1'b0;
      end else if ((st_q == ST_HDR_LEN) && take && buf_data[S_POS]) begin
        frame_q <= 1'b1;
      end

      unique case (st_q)
        ST_HDR_TS: begin
          if (take) begin
            ts_q <= buf_data;
            st_q <= ST_HDR_LEN;
          end
        end
        ST_HDR_LEN: begin
          if (take) begin
            e_q    <= buf_data[E_POS];
            left_q <= len_in;
            st_q   <= (len_in == '0) ? ST_HDR_TS : ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (at_time) begin
            st_q <= ST_SEND;
          end else if (past) begin
            st_q <= ST_DRAIN;
          end
        end
        ST_SEND, ST_DRAIN: begin
          if (take) begin
            left_q <= left_q - 1'b1;
            if (last) st_q <= ST_HDR_TS;
          end
        end
        default: st_q <= ST_HDR_TS;
      endcase
    end
  end

endmodule

// File: rtl/tx_time_sched.sv
module tx_time_sched #(
  parameter int WORD_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [WORD_W-1:0]   buf_data,
  input  logic                buf_valid,
  output logic                buf_ready,
  input  logic                tx_tick,
  input  logic [1:0]          sts_clr,
  output logic                smp_valid,
  output logic [WORD_W/2-1:0] smp_i,
  output logic [WORD_W/2-1:0] smp_q,
  output logic                late_evt,
  output logic                undr_evt,
  output logic                late_sticky,
  output logic                undr_sticky,
  output logic [WORD_W-1:0]   time_now
);

  localparam int HALF_W = WORD_W / 2;

  logic [HALF_W-1:0] lo_w;
  logic [HALF_W-1:0] hi_w;
  logic              cy_w;
  logic [WORD_W-1:0] ts_w;
  logic              at_time_w;
  logic              past_w;
  logic              late_hit_w;
  logic              undr_hit_w;
  logic [1:0]        evt_w;
  logic [1:0]        sticky_w;

  sched_time_ctr #(.HALF_W(HALF_W)) u_ctr (
    .clk  (clk),
    .rst_n(rst_n),
    .lo_q (lo_w),
    .hi_q (hi_w),
    .cy_q (cy_w)
  );

  sched_time_cmp #(.TIME_W(WORD_W)) u_cmp (
    .ts     (ts_w),
    .lo     (lo_w),
    .hi     (hi_w),
    .cy     (cy_w),
    .now    (time_now),
    .at_time(at_time_w),
    .past   (past_w)
  );

  sched_release_fsm #(.WORD_W(WORD_W)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .buf_data (buf_data),
    .buf_valid(buf_valid),
    .buf_ready(buf_ready),
    .tx_tick  (tx_tick),
    .at_time  (at_time_w),
    .past     (past_w),
    .ts_q     (ts_w),
    .smp_valid(smp_valid),
    .smp_i    (smp_i),
    .smp_q    (smp_q),
    .late_hit (late_hit_w),
    .undr_hit (undr_hit_w)
  );

  sched_flags #(.N(2)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .hit   ({undr_hit_w, late_hit_w}),
    .clr   (sts_clr),
    .evt   (evt_w),
    .sticky(sticky_w)
  );

  assign late_evt    = evt_w[0];
  assign undr_evt    = evt_w[1];
  assign late_sticky = sticky_w[0];
  assign undr_sticky = sticky_w[1];

endmodule

// File: rtl/tx_time_sched_chk.sv
module tx_time_sched_chk #(
  parameter int TIME_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_tick,
  input logic              buf_valid,
  input logic              buf_ready,
  input logic [1:0]        sts_clr,
  input logic              smp_valid,
  input logic              late_evt,
  input logic              undr_evt,
  input logic              late_sticky,
  input logic              undr_sticky,
  input logic [TIME_W-1:0] time_now
);

  // R1
  time_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> time_now == $past(time_now) + TIME_W'(1));

  // R4
  smp_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> $past(tx_tick && buf_valid && buf_ready));

  // R5
  late_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({smp_valid, late_evt}));

  // R8
  late_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    late_evt |-> late_sticky);

  // R8
  undr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    undr_evt |-> undr_sticky);

  // R8
  late_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(late_sticky) |-> $past(sts_clr[0]));

  // R8
  undr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(undr_sticky) |-> $past(sts_clr[1]));

endmodule

bind tx_time_sched tx_time_sched_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .tx_tick    (tx_tick),
  .buf_valid  (buf_valid),
  .buf_ready  (buf_ready),
  .sts_clr    (sts_clr),
  .smp_valid  (smp_valid),
  .late_evt   (late_evt),
  .undr_evt   (undr_evt),
  .late_sticky(late_sticky),
  .undr_sticky(undr_sticky),
  .time_now   (time_now)
);

// File: tb/tx_time_sched_tb_top.sv
module tx_time_sched_tb_top;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n;
  logic [31:0] buf_data;
  logic        buf_valid;
  logic        buf_ready;
  logic        tx_tick;
  logic [1:0]  sts_clr;
  logic        smp_valid;
  logic [15:0] smp_i;
  logic [15:0] smp_q;
  logic        late_evt, undr_evt, late_sticky, undr_sticky;
  logic [31:0] time_now;

  tx_time_sched dut_i (
    .clk(clk), .rst_n(rst_n), .buf_data(buf_data), .buf_valid(buf_valid),
    .buf_ready(buf_ready), .tx_tick(tx_tick), .sts_clr(sts_clr),
    .smp_valid(smp_valid), .smp_i(smp_i), .smp_q(smp_q),
    .late_evt(late_evt), .undr_evt(undr_evt), .late_sticky(late_sticky),
    .undr_sticky(undr_sticky), .time_now(time_now)
  );

  int errs = 0;
  int checks = 0;

  logic [31:0] q[$];
  int          tick_div = 1;
  bit          gap_mode = 1'b0;
  logic [1:0]  clr_pend = 2'b00;
  bit          loop_run = 1'b0;

  // reference model state
  logic [31:0] m_time = 0;
  int          m_st = 0;   // 0 ts word, 1 descriptor, 2 hold, 3 send, 4 drain
  logic [31:0] m_ts = 0;
  int          m_left = 0;
  bit          m_e = 0, m_frame = 0;
  bit          m_sv = 0, m_late = 0, m_undr = 0, m_lst = 0, m_ust = 0;
  logic [15:0] m_i = 0, m_q = 0;

  int          smp_cnt = 0;
  bit          arm = 1'b0;
  logic [31:0] first_t = 0;
  logic [15:0] first_i = 0, first_q = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push_pkt(logic [31:0] ts, bit s, bit e, int n, logic [15:0] base);
    q.push_back(ts);
    q.push_back({s, e, 30'(n)});
    for (int k = 0; k < n; k++) begin
      logic [15:0] v;
      v = base + 16'(k);
      q.push_back({v, ~v});
    end
  endtask

  task automatic wait_t(logic [31:0] t);
    while (m_time < t) @(negedge clk);
  endtask

  // per-cycle compare, stimulus drive and model step
  always @(negedge clk) begin
    if (loop_run) begin
      bit rdy, take, n_late, n_undr;
      int n;
      chk(time_now == m_time, "R1", "time_now", time_now, m_time);
      chk(smp_valid == m_sv, "R4", "smp_valid", smp_valid, m_sv);
      if (m_sv) begin
        chk(smp_i == m_i, "R2", "smp_i", smp_i, m_i);
        chk(smp_q == m_q, "R2", "smp_q", smp_q, m_q);
      end
      chk(late_evt == m_late, "R5", "late_evt", late_evt, m_late);
      chk(undr_evt == m_undr, "R6", "undr_evt", undr_evt, m_undr);
      chk(late_sticky == m_lst, "R8", "late_sticky", late_sticky, m_lst);
      chk(undr_sticky == m_ust, "R8", "undr_sticky", undr_sticky, m_ust);
      if (smp_valid) begin
        smp_cnt++;
        if (arm) begin
          first_t = time_now; first_i = smp_i; first_q = smp_q; arm = 1'b0;
        end
      end

      tx_tick   = ((m_time % 32'(tick_div)) == 0);
      buf_valid = (q.size() > 0) && (!gap_mode || m_time[0]);
      buf_data  = (q.size() > 0) ? q[0] : 32'h0;
      sts_clr   = clr_pend;
      clr_pend  = 2'b00;
      #1;
      rdy = (m_st == 0) || (m_st == 1) || (m_st == 4) || ((m_st == 3) && tx_tick);
      chk(buf_ready == rdy, "R10", "buf_ready", buf_ready, rdy);
      take = rdy && buf_valid;
      if (take) void'(q.pop_front());

      n_late = (m_st == 2) && (m_ts != m_time) && ($signed(m_ts - m_time) < 0);
      n_undr = tx_tick && m_frame && !buf_valid && (m_st == 0 || m_st == 1 || m_st == 3);
      m_sv = (m_st == 3) && take;
      if (m_sv) begin m_i = buf_data[31:16]; m_q = buf_data[15:0]; end
      m_lst  = n_late | (m_lst & !sts_clr[0]);
      m_ust  = n_undr | (m_ust & !sts_clr[1]);
      m_late = n_late;
      m_undr = n_undr;
      case (m_st)
        0: if (take) begin m_ts = buf_data; m_st = 1; end
        1: if (take) begin
             n = int'(buf_data[29:0]);
             if (buf_data[31]) m_frame = 1;
             m_e = buf_data[30];
             if (n == 0) begin
               if (m_e) m_frame = 0;
               m_st = 0;
             end else begin
               m_left = n; m_st = 2;
             end
           end
        2: if (m_ts == m_time) m_st = 3; else if (n_late) m_st = 4;
        default: if (take) begin
             m_left--;
             if (m_left == 0) begin
               if (m_e) m_frame = 0;
               m_st = 0;
             end
           end
      endcase
      m_time = m_time + 1;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int c0;
    rst_n = 1'b0; tx_tick = 1'b0; buf_valid = 1'b0; buf_data = '0; sts_clr = '0;
    repeat (4) @(posedge clk);
    #2;
    // R9 reset state
    chk(buf_ready == 1'b1, "R9", "buf_ready", buf_ready, 1);
    chk({smp_valid, late_evt, undr_evt, late_sticky, undr_sticky} == 5'b0,
        "R9", "outputs", {smp_valid, late_evt, undr_evt, late_sticky, undr_sticky}, 0);
    chk(time_now == 0, "R1", "time in reset", time_now, 0);
    rst_n = 1'b1;
    loop_run = 1'b1;

    // exact-time release
    tick_div = 1; arm = 1'b1; c0 = smp_cnt;
    push_pkt(32'd40, 1, 1, 4, 16'h1000);
    wait_t(60);
    chk(first_t == 32'd42, "R3", "first sample time", first_t, 42);
    chk(first_i == 16'h1000 && first_q == 16'hefff, "R2", "first sample I/Q",
        {first_i, first_q}, 32'h1000efff);
    chk(smp_cnt - c0 == 4, "R4", "sample count", smp_cnt - c0, 4);

    // late packet skipped, followed by a good one
    c0 = smp_cnt;
    push_pkt(32'd10, 1, 1, 3, 16'h2000);
    push_pkt(32'd100, 1, 1, 2, 16'h2100);
    wait_t(120);
    chk(smp_cnt - c0 == 2, "R5", "samples after skip", smp_cnt - c0, 2);
    chk(late_sticky == 1'b1, "R8", "late sticky set", late_sticky, 1);
    clr_pend = 2'b01;
    wait_t(125);
    chk(late_sticky == 1'b0, "R8", "late sticky cleared", late_sticky, 0);

    // mid-frame underrun with slower tick
    tick_div = 2;
    push_pkt(32'd200, 1, 0, 3, 16'h3000);
    wait_t(240);
    chk(undr_sticky == 1'b1, "R6", "underrun mid-frame", undr_sticky, 1);
    push_pkt(32'd300, 0, 1, 2, 16'h3100);
    wait_t(330);
    clr_pend = 2'b10;
    wait_t(340);
    chk(undr_sticky == 1'b0, "R6", "underrun cleared after end", undr_sticky, 0);

    // two-packet frame with time gap, then idle after end flag
    tick_div = 1; c0 = smp_cnt;
    push_pkt(32'd500, 1, 0, 3, 16'h4000);
    push_pkt(32'd510, 0, 1, 2, 16'h4100);
    wait_t(700);
    chk(undr_sticky == 1'b0, "R7", "no underrun in gap or idle", undr_sticky, 0);
    chk(smp_cnt - c0 == 5, "R7", "frame sample count", smp_cnt - c0, 5);

    // zero-count packet and a throttled buffer
    gap_mode = 1'b1; c0 = smp_cnt;
    push_pkt(32'd800, 0, 0, 0, 16'h0);
    push_pkt(32'd820, 0, 0, 2, 16'h5000);
    wait_t(860);
    chk(smp_cnt - c0 == 2, "R11", "zero-count packet output", smp_cnt - c0, 2);
    gap_mode = 1'b0;

    // timestamp beyond the half-counter carry
    arm = 1'b1;
    push_pkt(32'h0001_0003, 1, 1, 2, 16'h6000);
    wait_t(32'h0001_0020);
    chk(first_t == 32'h0001_0005, "R1", "release across carry", first_t, 32'h0001_0005);
    chk(late_sticky == 1'b0, "R3", "no late across carry", late_sticky, 0);

    loop_run = 1'b0;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule